// File: doc/BRIEF.md
# Bit-Band Alias Access Translator

This block sits on the path from a simple memory-bus master to a 32-bit word-addressed memory. It gives single-bit access to a 1 MB real region through a 32 MB alias window. Each byte of the real region owns eight consecutive alias words, one for each bit. The alias word address is the alias base plus 32 times the byte offset plus 4 times the bit number. Any address outside the window goes to the memory untouched.

An alias read becomes one memory read of the containing word, and the master receives the target bit in bit 0 with all other bits zero. An alias write becomes a locked read of the containing word followed by a write of the same word in which only the target bit is replaced by bit 0 of the write data. The master is held off with its ready signal until the last memory access of the operation completes. A lock output tells the memory side that the two accesses of a read-modify-write must not be split.

The master holds its request, address, write flag and write data steady until it sees ready. The memory answers each access with an acknowledge after any number of wait cycles. For reads, the data is valid in the acknowledge cycle.

Top module: `bb_alias_xlate`

## Requirements
- R1: An address below 0x22000000 or at or above 0x24000000 is forwarded unchanged. Address, write flag and write data pass straight to the memory, and ready and read data pass straight back in the same cycle. The lock stays low.
- R2: For an alias address A, the byte offset is (A - 0x22000000) >> 5 and the bit number is A[4:2]. A[1:0] has no effect. The memory word address is (0x20000000 + byte offset) with bits [1:0] cleared. The bit position inside that word is 8 × (byte offset mod 4) + bit number.
- R3: An alias read issues exactly one memory read. The master gets 0x00000001 if the target bit is set and 0x00000000 if it is clear.
- R4: An alias write issues one memory read and then one memory write to the same word. The written word equals the word read, except that the target bit takes the value of write-data bit 0. Write-data bits [31:1] have no effect.
- R5: The lock is high in every cycle in which an alias access drives the memory. It covers the read and the write of one alias write without a gap.
- R6: Ready is raised only in the acknowledge cycle of the last memory access of a request. A pass-through access or an alias read takes wait+1 cycles, and an alias write takes twice that.
- R7: While reset is low and after it, with no request, the memory request, lock and ready are all low. A reset during the write phase of an alias write abandons it, and no memory write is issued.
- R8: Alias address 0x22006008 selects bit 2 of the byte at 0x20000300, which is bit 2 of the word at 0x20000300.
- R9: The last alias word 0x23FFFFFC selects bit 31 of the word at 0x200FFFFC. The addresses 0x21FFFFFC and 0x24000000 are treated as outside the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| m_req | input | 1 | Master request, held until m_ready |
| m_we | input | 1 | Master write flag |
| m_addr | input | 32 | Master byte address |
| m_wdata | input | 32 | Master write data |
| m_ready | output | 1 | Request complete in this cycle |
| m_rdata | output | 32 | Read data, valid with m_ready |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write flag |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |
| mem_ack | input | 1 | Memory access done in this cycle |
| mem_lock | output | 1 | Accesses must not be split from the next one |

## Verification
The bench builds the block with its default parameters: a 32-bit bus, the alias window at 0x22000000, the real region at 0x20000000 and a 20-bit region size. With these values, both edges of the window, all four byte lanes of a word and the top bit of the last real byte can be reached with a handful of fixed addresses. The memory model in the bench answers with 0, 1 or 2 wait cycles, varied per access. This moves the read-to-write switch of an alias write across several acknowledge timings. A reset injected during the write phase shows that the abandoned operation leaves memory untouched.

// File: rtl/bb_xlate_pkg.sv
// Shared types for the bit-band alias translator.
// Assumes: nothing beyond the IEEE 1800-2017 language.
package bb_xlate_pkg;
    // Phase of an alias operation; PH_READ is also the idle phase.
    typedef enum logic {
        PH_READ  = 1'b0,
        PH_WRITE = 1'b1
    } phase_e;
endpackage

// File: rtl/bb_alias_decode.sv
// Decodes a word index (byte address without bits [1:0]) against the alias window.
// Yields the hit flag, the real word address and the bit position in that word.
// Assumes: ALIAS_BASE and REAL_BASE are word aligned.
module bb_alias_decode #(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int REGION_AW = 20,
    parameter logic [AW-1:0] ALIAS_BASE = 32'h2200_0000,
    parameter logic [AW-1:0] REAL_BASE  = 32'h2000_0000
) (
    input  logic [AW-3:0]          word_idx,
    output logic                   hit,
    output logic [AW-1:0]          real_word_addr,
    output logic [$clog2(DW)-1:0]  bit_pos
);
    localparam int LANE_W = $clog2(DW / 8);
    localparam int WIN_AW = REGION_AW + 5;
    localparam logic [AW-3:0] BASE_IDX = ALIAS_BASE[AW-1:2];

    logic [AW-3:0]        delta;
    logic [REGION_AW-1:0] byte_off;

    // Offset into the window, split into byte offset and bit number.
    always_comb begin
        delta          = word_idx - BASE_IDX;
        hit            = (word_idx >= BASE_IDX) && (delta[AW-3:WIN_AW-2] == '0);
        byte_off       = delta[WIN_AW-3:3];
        real_word_addr = REAL_BASE + AW'({byte_off[REGION_AW-1:LANE_W], {LANE_W{1'b0}}});
        bit_pos        = {byte_off[LANE_W-1:0], delta[2:0]};
    end
endmodule

// File: rtl/bb_bit_merge.sv
// Replaces one bit of a word and leaves every other bit as it was.
// Assumes: bit_pos is below DW.
module bb_bit_merge #(
    parameter int DW = 32
) (
    input  logic [DW-1:0]          word_in,
    input  logic [$clog2(DW)-1:0]  bit_pos,
    input  logic                   new_bit,
    output logic [DW-1:0]          word_out
);
    // One selector per bit lane.
    for (genvar i = 0; i < DW; i++) begin : g_lane
        assign word_out[i] = (bit_pos == i) ? new_bit : word_in[i];
    end
endmodule

// File: rtl/bb_phase_ctrl.sv
// Sequences an alias operation: a locked read, then, for writes, a locked write.
// Assumes: the master holds its request steady until done.
module bb_phase_ctrl
    import bb_xlate_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start,
    input  logic   is_write,
    input  logic   mem_ack,
    output phase_e phase,
    output logic   lock,
    output logic   issue_we,
    output logic   done,
    output logic   capture
);
    // Phase register: the read ack of a write moves to PH_WRITE, the write ack returns.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_READ;
        end else begin
            case (phase)
                PH_READ:  if (start && mem_ack && is_write) phase <= PH_WRITE;
                PH_WRITE: if (mem_ack) phase <= PH_READ;
                default:  phase <= PH_READ;
            endcase
        end
    end

    // Handshake outputs derived from the phase.
    always_comb begin
        lock     = start || (phase == PH_WRITE);
        issue_we = (phase == PH_WRITE);
        capture  = (phase == PH_READ) && start && mem_ack && is_write;
        done     = (phase == PH_WRITE) ? mem_ack : (start && mem_ack && !is_write);
    end
endmodule

// File: rtl/bb_alias_xlate.sv
// Bit-band alias translator. Alias reads return one bit; alias writes become a
// locked read-modify-write of one bit. Other addresses pass through.
// Assumes: the master holds its request until m_ready; the memory acks every access.
module bb_alias_xlate
    import bb_xlate_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int REGION_AW = 20,
    parameter logic [AW-1:0] ALIAS_BASE = 32'h2200_0000,
    parameter logic [AW-1:0] REAL_BASE  = 32'h2000_0000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          m_req,
    input  logic          m_we,
    input  logic [AW-1:0] m_addr,
    input  logic [DW-1:0] m_wdata,
    output logic          m_ready,
    output logic [DW-1:0] m_rdata,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_ack,
    output logic          mem_lock
);
    localparam int BIT_W = $clog2(DW);

    logic             hit;
    logic [AW-1:0]    word_addr;
    logic [BIT_W-1:0] bit_pos;
    logic [DW-1:0]    word_q;
    logic [DW-1:0]    merged;
    phase_e           phase;
    logic             issue_we;
    logic             done;
    logic             capture;
    logic             sel_alias;

    bb_alias_decode #(
        .AW(AW), .DW(DW), .REGION_AW(REGION_AW),
        .ALIAS_BASE(ALIAS_BASE), .REAL_BASE(REAL_BASE)
    ) decode_i (
        .word_idx       (m_addr[AW-1:2]),
        .hit            (hit),
        .real_word_addr (word_addr),
        .bit_pos        (bit_pos)
    );

    bb_phase_ctrl ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (m_req && hit),
        .is_write (m_we),
        .mem_ack  (mem_ack),
        .phase    (phase),
        .lock     (mem_lock),
        .issue_we (issue_we),
        .done     (done),
        .capture  (capture)
    );

    bb_bit_merge #(.DW(DW)) merge_i (
        .word_in  (word_q),
        .bit_pos  (bit_pos),
        .new_bit  (m_wdata[0]),
        .word_out (merged)
    );

    // Holds the word read during the first half of an alias write.
    always_ff @(posedge clk) begin
        if (!rst_n)       word_q <= '0;
        else if (capture) word_q <= mem_rdata;
    end

    // Steers either the alias sequence or the untouched request to the memory.
    always_comb begin
        sel_alias = (m_req && hit) || (phase == PH_WRITE);
        if (sel_alias) begin
            mem_req   = 1'b1;
            mem_we    = issue_we;
            mem_addr  = word_addr;
            mem_wdata = merged;
            m_ready   = done;
            m_rdata   = {{(DW-1){1'b0}}, mem_rdata[bit_pos]};
        end else begin
            mem_req   = m_req;
            mem_we    = m_we;
            mem_addr  = m_addr;
            mem_wdata = m_wdata;
            m_ready   = mem_ack && m_req;
            m_rdata   = mem_rdata;
        end
    end

    AST_PASS_UNCHANGED: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && !hit && !mem_lock) |-> (mem_addr == m_addr && mem_we == m_we)); // R1
    AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_lock) |-> (mem_addr[1:0] == 2'b00)); // R2
    AST_RDATA_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (m_ready && !m_we && hit) |-> (m_rdata[DW-1:1] == '0)); // R3
    AST_SINGLE_BIT_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_lock) |-> ($countones(mem_wdata ^ word_q) <= 1)); // R4
    AST_RMW_UNBROKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_lock && !mem_we && mem_ack && m_we) |=> (mem_req && mem_lock && mem_we)); // R5
    AST_READY_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        m_ready |-> mem_ack); // R6
    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!m_req && !mem_lock) |-> (!mem_req && !m_ready)); // R7
endmodule

// File: tb/bb_alias_xlate_tb.sv
`timescale 1ns/1ps
module bb_alias_xlate_tb_top;
    localparam int HALF = 4; // 125 MHz

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        m_req = 1'b0, m_we = 1'b0;
    logic [31:0] m_addr = '0, m_wdata = '0;
    logic        m_ready;
    logic [31:0] m_rdata;
    logic        mem_req, mem_we, mem_lock, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;

    always #HALF clk = ~clk;

    bb_alias_xlate dut_i (
        .clk(clk), .rst_n(rst_n), .m_req(m_req), .m_we(m_we), .m_addr(m_addr),
        .m_wdata(m_wdata), .m_ready(m_ready), .m_rdata(m_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack), .mem_lock(mem_lock)
    );

    // Memory model: a few named word slots plus a scratch slot.
    localparam logic [31:0] SLOT_ADDR [5] = '{32'h2000_0300, 32'h200F_FFFC,
                                              32'h2400_0000, 32'h21FF_FFFC, 32'hFFFF_FFFF};
    logic [31:0] mem_arr [5];
    int          lat = 0;
    int          wcnt;
    bit          do_preload = 1'b1;

    function automatic int slot_of(input logic [31:0] a);
        for (int k = 0; k < 4; k++) if (SLOT_ADDR[k] == a) return k;
        return 4;
    endfunction

    assign mem_ack = mem_req && (wcnt == lat);
    always_comb mem_rdata = mem_arr[slot_of(mem_addr)];

    always @(posedge clk) begin
        if (!rst_n) wcnt <= 0;
        else if (mem_req && !mem_ack) wcnt <= wcnt + 1;
        else wcnt <= 0;
        if (!rst_n && do_preload) begin
            mem_arr[0] <= 32'h8001_0004;
            mem_arr[1] <= 32'h0000_0000;
            mem_arr[2] <= 32'hA5A5_A5A5;
            mem_arr[3] <= 32'h5A5A_5A5A;
            mem_arr[4] <= 32'h0000_0000;
        end else if (mem_req && mem_ack && mem_we) begin
            mem_arr[slot_of(mem_addr)] <= mem_wdata;
        end
    end

    // Port monitor: counts memory accesses and lock state per transfer.
    int          n_rd, n_wr, n_lk, n_unlk;
    logic [31:0] last_addr;
    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_lock) n_lk++; else n_unlk++;
            if (mem_ack) begin
                if (mem_we) n_wr++; else n_rd++;
                last_addr = mem_addr;
            end
        end
    end

    int n_cmp = 0, n_bad = 0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic xfer(input logic we, input logic [31:0] a, input logic [31:0] wd,
                        output logic [31:0] rd, output int cyc);
        @(negedge clk);
        m_req = 1'b1; m_we = we; m_addr = a; m_wdata = wd;
        n_rd = 0; n_wr = 0; n_lk = 0; n_unlk = 0;
        cyc = 1;
        #1;
        while (!m_ready) begin
            @(negedge clk);
            cyc++;
            #1;
        end
        rd = m_rdata;
        @(posedge clk);
        #1;
        m_req = 1'b0;
    endtask

    function automatic bit in_alias(input logic [31:0] a);
        return (a >= 32'h2200_0000) && (a < 32'h2400_0000);
    endfunction

    // Fields: we | addr | wdata | word to inspect | expected (rdata or word value)
    localparam logic [128:0] VEC [16] = '{
        {1'b0, 32'h2200_6008, 32'h0, 32'h0,          32'h0000_0001},
        {1'b0, 32'h2200_6000, 32'h0, 32'h0,          32'h0000_0000},
        {1'b1, 32'h2200_6000, 32'hFFFF_FFFF, 32'h2000_0300, 32'h8001_0005},
        {1'b1, 32'h2200_6008, 32'hFFFF_FFFE, 32'h2000_0300, 32'h8001_0001},
        {1'b0, 32'h2200_600B, 32'h0, 32'h0,          32'h0000_0000},
        {1'b0, 32'h2200_6040, 32'h0, 32'h0,          32'h0000_0001},
        {1'b0, 32'h2200_607C, 32'h0, 32'h0,          32'h0000_0001},
        {1'b1, 32'h2200_6060, 32'h0000_0001, 32'h2000_0300, 32'h8101_0001},
        {1'b1, 32'h2000_0300, 32'h1234_5678, 32'h2000_0300, 32'h1234_5678},
        {1'b0, 32'h2000_0300, 32'h0, 32'h0,          32'h1234_5678},
        {1'b1, 32'h23FF_FFFC, 32'h0000_0001, 32'h200F_FFFC, 32'h8000_0000},
        {1'b0, 32'h23FF_FFFC, 32'h0, 32'h0,          32'h0000_0001},
        {1'b0, 32'h2400_0000, 32'h0, 32'h0,          32'hA5A5_A5A5},
        {1'b0, 32'h21FF_FFFC, 32'h0, 32'h0,          32'h5A5A_5A5A},
        {1'b1, 32'h23FF_FFFC, 32'hFFFF_FFFE, 32'h200F_FFFC, 32'h0000_0000},
        {1'b0, 32'h2200_6064, 32'h0, 32'h0,          32'h0000_0001}
    };

    initial begin
        #(2 * HALF * 50000);
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        int          cyc;
        repeat (3) @(posedge clk);
        #1;
        // R7: quiet outputs while in reset
        check("R7 reset mem_req", {31'b0, mem_req}, 32'h0);
        check("R7 reset mem_lock", {31'b0, mem_lock}, 32'h0);
        check("R7 reset m_ready", {31'b0, m_ready}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < 16; i++) begin
            logic        we;
            logic [31:0] a, wd, ca, ex;
            bit          al;
            string       tag;
            int          unit;
            {we, a, wd, ca, ex} = VEC[i];
            lat = i % 3;
            unit = lat + 1;
            al = in_alias(a);
            tag = al ? (we ? "R4" : "R3") : "R1";
            xfer(we, a, wd, rd, cyc);
            if (we) check($sformatf("%s vec%0d word", tag, i), mem_arr[slot_of(ca)], ex);
            else    check($sformatf("%s vec%0d rdata", tag, i), rd, ex);
            if (al) begin
                check($sformatf("R5 vec%0d unlocked cycles", i), n_unlk, 0);
                check($sformatf("%s vec%0d reads", tag, i), n_rd, 1);
                check($sformatf("%s vec%0d writes", tag, i), n_wr, we ? 1 : 0);
                check($sformatf("R6 vec%0d cycles", i), cyc, we ? 2 * unit : unit);
            end else begin
                check($sformatf("R1 vec%0d locked cycles", i), n_lk, 0);
                check($sformatf("R1 vec%0d addr", i), last_addr, a);
                check($sformatf("R6 vec%0d cycles", i), cyc, unit);
            end
        end

        // R8: worked example of the mapping
        lat = 1;
        xfer(1'b0, 32'h2200_6008, 32'h0, rd, cyc);
        check("R8 word address", last_addr, 32'h2000_0300);
        check("R8 rdata bit2 of 0x78", rd, 32'h0);
        // R2: low address bits ignored, lane from byte offset
        xfer(1'b0, 32'h2200_606F, 32'h0, rd, cyc);
        check("R2 lane3 word address", last_addr, 32'h2000_0300);
        check("R2 lane3 bit3 of 0x12", rd, 32'h0);
        xfer(1'b0, 32'h2200_6070, 32'h0, rd, cyc);
        check("R2 lane3 bit4 of 0x12", rd, 32'h1);
        // R9: window edges
        xfer(1'b0, 32'h23FF_FFFC, 32'h0, rd, cyc);
        check("R9 top word address", last_addr, 32'h200F_FFFC);
        xfer(1'b0, 32'h2400_0000, 32'h0, rd, cyc);
        check("R9 upper edge locked", n_lk, 0);
        xfer(1'b0, 32'h21FF_FFFC, 32'h0, rd, cyc);
        check("R9 lower edge addr", last_addr, 32'h21FF_FFFC);

        // R7: reset during the write phase abandons the write
        lat = 3;
        @(negedge clk);
        m_req = 1'b1; m_we = 1'b1; m_addr = 32'h2200_6000; m_wdata = 32'h1;
        n_wr = 0;
        repeat (5) @(negedge clk);
        #1;
        check("R7 in write phase lock", {31'b0, mem_lock}, 32'h1);
        do_preload = 1'b0;
        rst_n = 1'b0;
        m_req = 1'b0;
        @(posedge clk);
        #1;
        check("R7 after reset mem_req", {31'b0, mem_req}, 32'h0);
        check("R7 after reset mem_lock", {31'b0, mem_lock}, 32'h0);
        check("R7 no write issued", n_wr, 0);
        @(negedge clk);
        rst_n = 1'b1;
        lat = 0;
        xfer(1'b0, 32'h2000_0300, 32'h0, rd, cyc);
        check("R7 word untouched", rd, 32'h1234_5678);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule